// File: doc/BRIEF.md
# ECC Error Reporting and Capture Unit

This unit sits beside the ECC decoders of an on-chip RAM and an on-chip flash array. Each decoder pulses an event input when it corrects a single-bit error or detects an error it cannot correct, and presents the faulting address, bus attributes and data alongside the pulse. Software chooses which classes of event are reported by programming an 8-bit configuration register. An event of an enabled class updates an 8-bit status register, records its details in a capture record kept for its memory, and raises an interrupt request.

The single-bit classes can only be turned on while a chip-level enable input is high. The status register holds exactly one flag, naming the most recent enabled event. Events that are not enabled leave every register and the interrupt untouched. A byte-wide port with a combinational read path gives access to the configuration, the status and, read-only, the bytes of both capture records.

Top module: `ecc_err_report`

## Requirements
- R1: After reset the configuration and status registers read 0x00, every capture byte reads 0x00 and `irq` is low.
- R2: Configuration bits (bit 0 = LSB) are: bit 5 RAM single-bit enable, bit 4 flash single-bit enable, bit 1 RAM non-correctable enable, bit 0 flash non-correctable enable; bits 7, 6, 3 and 2 always read 0. The configuration sits at byte address 0x00, the status at 0x01.
- R3: A write of 1 to bit 5 or bit 4 of the configuration takes effect only while `soc_sbit_en` is high; with it low the bit stays 0. Writing 0 to any enable always clears it.
- R4: An enabled event sets its status flag, at the same bit position as its enable, clears all other flags, and drives `irq` high; `irq` is high exactly while some flag is set.
- R5: When several enabled events arrive in one cycle, the flag set is chosen in the order RAM non-correctable, flash non-correctable, RAM single-bit, flash single-bit.
- R6: An event whose class is disabled changes neither the status register, nor any capture record, nor `irq`.
- R7: An enabled event on a memory captures {address, attributes, data} into that memory's record; record byte k (k=0 is the least significant data byte, then attributes, then address) reads at 0x10+k for RAM and 0x20+k for flash. Unmapped addresses read 0x00.
- R8: A capture record keeps its value until the next enabled event on the same memory; status clears, writes to capture addresses and events on the other memory leave it unchanged.
- R9: Writing 1 to a status bit clears that flag (write-1-to-clear); an enabled event in the same cycle takes precedence over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soc_sbit_en | input | 1 | Chip-level permission to turn on single-bit reporting |
| reg_addr | input | ADDR_W (6) | Register byte address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| ram_sbit | input | 1 | RAM single-bit correction event |
| ram_ncor | input | 1 | RAM non-correctable error event |
| ram_addr | input | AW (32) | RAM faulting address |
| ram_attr | input | ATW (8) | RAM access attributes |
| ram_data | input | DW (32) | RAM faulting data |
| fl_sbit | input | 1 | Flash single-bit correction event |
| fl_ncor | input | 1 | Flash non-correctable error event |
| fl_addr | input | AW (32) | Flash faulting address |
| fl_attr | input | ATW (8) | Flash access attributes |
| fl_data | input | DW (32) | Flash faulting data |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume event inputs are single-cycle pulses sampled at the clock edge with address, attributes and data valid in that same cycle, and that reset is held low for at least one edge before any event or register write. They also take a status write with no enabled event present as the only way flags may drop. The bench holds every event pulse for exactly one clock, changes inputs only at the falling edge, and never issues a register write in the cycle an event is presented except in the one directed case that checks event-over-clear precedence.

// File: rtl/ecc_rpt_pkg.sv
// Package: shared bit positions and masks for the ECC reporting unit.
// Assumes bit 0 is the least significant bit of every 8-bit register.
package ecc_rpt_pkg;
    localparam int BIT_RSB = 5;
    localparam int BIT_FSB = 4;
    localparam int BIT_RNC = 1;
    localparam int BIT_FNC = 0;
    localparam logic [7:0] SB_MASK  = 8'h30;
    localparam logic [7:0] NC_MASK  = 8'h03;
    localparam logic [7:0] EV_MASK  = SB_MASK | NC_MASK;
    localparam logic [1:0] REGION_CTL = 2'd0;
    localparam logic [1:0] REGION_RAM = 2'd1;
    localparam logic [1:0] REGION_FL  = 2'd2;
    localparam logic [3:0] IDX_CFG  = 4'h0;
    localparam logic [3:0] IDX_STAT = 4'h1;
endpackage

// File: rtl/ecc_rpt_cfg.sv
// Module: configuration register holding the four reporting enables.
// Assumes the write strobe is already decoded to this register's address.
// Single-bit enables can be set only while soc_sbit_en is high.
module ecc_rpt_cfg
    import ecc_rpt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    input  logic       soc_sbit_en,
    output logic [7:0] cfg_q
);
    logic [7:0] sb_allow;

    // Purpose: a single-bit enable may be set with the permission input, or kept if already set.
    always_comb sb_allow = {8{soc_sbit_en}} | cfg_q;

    // Purpose: register update on a decoded write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= 8'h00;
        end else if (wr_en) begin
            cfg_q <= (wdata & NC_MASK) | (wdata & SB_MASK & sb_allow);
        end
    end
endmodule

// File: rtl/ecc_rpt_status.sv
// Module: qualifies events against the enables, picks one winner and keeps
// the one-hot status register with write-1-to-clear.
// Assumes ev_vec carries events at the same bit positions as their enables.
module ecc_rpt_status
    import ecc_rpt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] ev_vec,
    input  logic [7:0] cfg_q,
    input  logic       clr_wr,
    input  logic [7:0] clr_mask,
    output logic [7:0] qual,
    output logic       hit_ram,
    output logic       hit_fl,
    output logic [7:0] status_q
);
    logic [7:0] win;

    // Purpose: drop events whose class is disabled.
    always_comb qual = ev_vec & cfg_q & EV_MASK;

    // Purpose: fixed priority, non-correctable before single-bit, RAM before flash.
    always_comb begin
        win = 8'h00;
        if (qual[BIT_RNC])      win[BIT_RNC] = 1'b1;
        else if (qual[BIT_FNC]) win[BIT_FNC] = 1'b1;
        else if (qual[BIT_RSB]) win[BIT_RSB] = 1'b1;
        else if (qual[BIT_FSB]) win[BIT_FSB] = 1'b1;
    end

    // Purpose: per-memory capture strobes.
    always_comb begin
        hit_ram = qual[BIT_RNC] | qual[BIT_RSB];
        hit_fl  = qual[BIT_FNC] | qual[BIT_FSB];
    end

    // Purpose: status register; a new event wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= 8'h00;
        end else if (|qual) begin
            status_q <= win;
        end else if (clr_wr) begin
            status_q <= status_q & ~clr_mask;
        end
    end
endmodule

// File: rtl/ecc_rpt_capture.sv
// Module: one memory's capture record {address, attributes, data}.
// Assumes cap_en is a one-cycle strobe for an enabled event on this memory.
module ecc_rpt_capture #(
    parameter int AW  = 32,
    parameter int ATW = 8,
    parameter int DW  = 32,
    localparam int REC_W = AW + ATW + DW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic [AW-1:0]    addr,
    input  logic [ATW-1:0]   attr,
    input  logic [DW-1:0]    data,
    output logic [REC_W-1:0] rec
);
    // Purpose: load the record on an enabled event, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec <= '0;
        end else if (cap_en) begin
            rec <= {addr, attr, data};
        end
    end
endmodule

// File: rtl/ecc_err_report.sv
// Module: top of the ECC reporting unit. Decodes the byte register port,
// routes events to the status logic and the two capture records, and
// drives the interrupt from the status flags.
// Assumes ADDR_W >= 6 and each record fits in 16 bytes.
module ecc_err_report
    import ecc_rpt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int AW     = 32,
    parameter int ATW    = 8,
    parameter int DW     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soc_sbit_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              ram_sbit,
    input  logic              ram_ncor,
    input  logic [AW-1:0]     ram_addr,
    input  logic [ATW-1:0]    ram_attr,
    input  logic [DW-1:0]     ram_data,
    input  logic              fl_sbit,
    input  logic              fl_ncor,
    input  logic [AW-1:0]     fl_addr,
    input  logic [ATW-1:0]    fl_attr,
    input  logic [DW-1:0]     fl_data,
    output logic              irq
);
    localparam int REC_W     = AW + ATW + DW;
    localparam int REC_BYTES = (REC_W + 7) / 8;
    localparam int NMEM      = 2;

    logic [1:0]       region;
    logic [3:0]       idx;
    logic             cfg_wr;
    logic             stat_wr;
    logic [7:0]       cfg_q;
    logic [7:0]       status_q;
    logic [7:0]       qual;
    logic [7:0]       ev_vec;
    logic             hit_ram;
    logic             hit_fl;
    logic [REC_W-1:0] ram_rec;
    logic [REC_W-1:0] fl_rec;

    logic [NMEM-1:0]                 m_cap;
    logic [NMEM-1:0][AW-1:0]         m_addr;
    logic [NMEM-1:0][ATW-1:0]        m_attr;
    logic [NMEM-1:0][DW-1:0]         m_data;
    logic [NMEM-1:0][REC_W-1:0]      m_rec;
    logic [NMEM-1:0][REC_BYTES*8-1:0] m_pad;

    // Purpose: split the byte address into region and index.
    always_comb begin
        region = reg_addr[ADDR_W-1 -: 2];
        idx    = reg_addr[3:0];
    end

    // Purpose: decode writes; capture regions take no writes.
    always_comb begin
        cfg_wr  = reg_wr && (region == REGION_CTL) && (idx == IDX_CFG);
        stat_wr = reg_wr && (region == REGION_CTL) && (idx == IDX_STAT);
    end

    // Purpose: place event pulses at their enable bit positions.
    always_comb begin
        ev_vec          = 8'h00;
        ev_vec[BIT_RSB] = ram_sbit;
        ev_vec[BIT_FSB] = fl_sbit;
        ev_vec[BIT_RNC] = ram_ncor;
        ev_vec[BIT_FNC] = fl_ncor;
    end

    ecc_rpt_cfg u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (cfg_wr),
        .wdata       (reg_wdata),
        .soc_sbit_en (soc_sbit_en),
        .cfg_q       (cfg_q)
    );

    ecc_rpt_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_vec   (ev_vec),
        .cfg_q    (cfg_q),
        .clr_wr   (stat_wr),
        .clr_mask (reg_wdata),
        .qual     (qual),
        .hit_ram  (hit_ram),
        .hit_fl   (hit_fl),
        .status_q (status_q)
    );

    // Purpose: gather per-memory inputs so the records can be generated.
    always_comb begin
        m_cap  = {hit_fl, hit_ram};
        m_addr = {fl_addr, ram_addr};
        m_attr = {fl_attr, ram_attr};
        m_data = {fl_data, ram_data};
    end

    for (genvar m = 0; m < NMEM; m++) begin : g_mem
        ecc_rpt_capture #(.AW(AW), .ATW(ATW), .DW(DW)) u_cap (
            .clk    (clk),
            .rst_n  (rst_n),
            .cap_en (m_cap[m]),
            .addr   (m_addr[m]),
            .attr   (m_attr[m]),
            .data   (m_data[m]),
            .rec    (m_rec[m])
        );
        assign m_pad[m] = (REC_BYTES*8)'(m_rec[m]);
    end

    assign ram_rec = m_rec[0];
    assign fl_rec  = m_rec[1];

    // Purpose: combinational read mux; unmapped addresses return zero.
    always_comb begin
        reg_rdata = 8'h00;
        unique case (region)
            REGION_CTL: begin
                if (idx == IDX_CFG)       reg_rdata = cfg_q;
                else if (idx == IDX_STAT) reg_rdata = status_q;
            end
            REGION_RAM: if (int'(idx) < REC_BYTES) reg_rdata = m_pad[0][int'(idx)*8 +: 8];
            REGION_FL:  if (int'(idx) < REC_BYTES) reg_rdata = m_pad[1][int'(idx)*8 +: 8];
            default:    reg_rdata = 8'h00;
        endcase
    end

    // Purpose: interrupt request while any flag is set.
    assign irq = |status_q;
endmodule

// File: rtl/ecc_rpt_chk.sv
// Module: property checker for the ECC reporting unit, bound to the top.
// Assumes reset is held for at least one clock edge before use.
module ecc_rpt_chk #(
    parameter int REC_W = 72
) (
    input logic             clk,
    input logic             rst_n,
    input logic             soc_sbit_en,
    input logic [7:0]       cfg_q,
    input logic [7:0]       status_q,
    input logic [7:0]       qual,
    input logic             stat_wr,
    input logic             hit_ram,
    input logic             hit_fl,
    input logic             irq,
    input logic [REC_W-1:0] ram_rec,
    input logic [REC_W-1:0] fl_rec
);
    // R3: RAM single-bit enable can only rise with permission present
    a_r3_ram_sb_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_q[5]) |-> $past(soc_sbit_en));
    // R3: flash single-bit enable likewise
    a_r3_fl_sb_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_q[4]) |-> $past(soc_sbit_en));
    // R4: never more than one status flag
    a_r4_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(status_q));
    // R4: interrupt only rises after an enabled event
    a_r4_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(|qual));
    // R5: RAM non-correctable wins every collision
    a_r5_ram_nc_first: assert property (@(posedge clk) disable iff (!rst_n)
        qual[1] |=> (status_q == 8'h02));
    // R6: no enabled event and no clear leaves status unchanged
    a_r6_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((qual == 8'h00) && !stat_wr) |=> $stable(status_q));
    // R8: RAM record held without an enabled RAM event
    a_r8_ram_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_ram |=> $stable(ram_rec));
    // R8: flash record held without an enabled flash event
    a_r8_fl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_fl |=> $stable(fl_rec));
endmodule

bind ecc_err_report ecc_rpt_chk #(.REC_W(REC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .soc_sbit_en (soc_sbit_en),
    .cfg_q       (cfg_q),
    .status_q    (status_q),
    .qual        (qual),
    .stat_wr     (stat_wr),
    .hit_ram     (hit_ram),
    .hit_fl      (hit_fl),
    .irq         (irq),
    .ram_rec     (ram_rec),
    .fl_rec      (fl_rec)
);

// File: tb/ecc_err_report_tb.sv
module ecc_err_report_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soc_sbit_en = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        ram_sbit = 0, ram_ncor = 0, fl_sbit = 0, fl_ncor = 0;
    logic [31:0] ram_addr = '0, ram_data = '0, fl_addr = '0, fl_data = '0;
    logic [7:0]  ram_attr = '0, fl_attr = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    ecc_err_report u_dut (
        .clk(clk), .rst_n(rst_n), .soc_sbit_en(soc_sbit_en),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ram_sbit(ram_sbit), .ram_ncor(ram_ncor), .ram_addr(ram_addr), .ram_attr(ram_attr), .ram_data(ram_data),
        .fl_sbit(fl_sbit), .fl_ncor(fl_ncor), .fl_addr(fl_addr), .fl_attr(fl_attr), .fl_data(fl_data),
        .irq(irq)
    );

    // vector: {soc[20], cfg write[19:12], events {rsb,rnc,fsb,fnc}[11:8], expected status[7:0]}
    localparam int NV = 13;
    localparam logic [20:0] VEC [NV] = '{
        {1'b1, 8'h33, 4'b1000, 8'h20},
        {1'b1, 8'h33, 4'b0010, 8'h10},
        {1'b1, 8'h33, 4'b0100, 8'h02},
        {1'b1, 8'h33, 4'b0001, 8'h01},
        {1'b0, 8'h33, 4'b1000, 8'h00},
        {1'b0, 8'h33, 4'b0010, 8'h00},
        {1'b1, 8'h33, 4'b1111, 8'h02},
        {1'b1, 8'h33, 4'b1011, 8'h01},
        {1'b1, 8'h33, 4'b1010, 8'h20},
        {1'b1, 8'h31, 4'b0101, 8'h01},
        {1'b1, 8'h30, 4'b0111, 8'h10},
        {1'b1, 8'h00, 4'b1111, 8'h00},
        {1'b1, 8'h20, 4'b1111, 8'h20}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pulse(input logic [3:0] ev);
        @(negedge clk);
        {ram_sbit, ram_ncor, fl_sbit, fl_ncor} = ev;
        @(negedge clk);
        {ram_sbit, ram_ncor, fl_sbit, fl_ncor} = 4'b0000;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        logic [7:0] exp_cfg;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(6'h00, r); chk("R1 cfg", r, 8'h00);
        rd(6'h01, r); chk("R1 status", r, 8'h00);
        rd(6'h10, r); chk("R1 ram byte0", r, 8'h00);
        rd(6'h28, r); chk("R1 flash byte8", r, 8'h00);
        chk("R1 irq", {7'b0, irq}, 8'h00);

        // Vector walk: R2 R3 R4 R5 R6
        for (int i = 0; i < NV; i++) begin
            soc_sbit_en = 1'b1;
            wr(6'h00, 8'h00);
            wr(6'h01, 8'hFF);
            soc_sbit_en = VEC[i][20];
            wr(6'h00, VEC[i][19:12]);
            exp_cfg = VEC[i][19:12] & (VEC[i][20] ? 8'h33 : 8'h03);
            rd(6'h00, r); chk("R3 cfg gate", r, exp_cfg);
            pulse(VEC[i][11:8]);
            rd(6'h01, r); chk("R5 status vector", r, VEC[i][7:0]);
            chk("R4 irq vector", {7'b0, irq}, {7'b0, |VEC[i][7:0]});
        end

        // R2: unused bits read zero
        soc_sbit_en = 1'b1;
        wr(6'h00, 8'hFF);
        rd(6'h00, r); chk("R2 unused bits", r, 8'h33);
        wr(6'h01, 8'hFF);

        // R7: RAM capture byte map
        ram_addr = 32'h1234_5678; ram_attr = 8'hA5; ram_data = 32'hDEAD_BEEF;
        fl_addr = 32'hCAFE_0001;  fl_attr = 8'h3C;  fl_data = 32'h0BAD_F00D;
        pulse(4'b1000);
        rd(6'h10, r); chk("R7 ram data lsb", r, 8'hEF);
        rd(6'h13, r); chk("R7 ram data msb", r, 8'hDE);
        rd(6'h14, r); chk("R7 ram attr", r, 8'hA5);
        rd(6'h18, r); chk("R7 ram addr msb", r, 8'h12);
        rd(6'h20, r); chk("R8 flash untouched", r, 8'h00);
        rd(6'h3F, r); chk("R7 unmapped", r, 8'h00);

        // R9: write-1-to-clear of a different bit keeps flag, matching bit clears
        wr(6'h01, 8'h10);
        rd(6'h01, r); chk("R9 other bit kept", r, 8'h20);
        wr(6'h01, 8'h20);
        rd(6'h01, r); chk("R9 cleared", r, 8'h00);
        chk("R9 irq low", {7'b0, irq}, 8'h00);
        rd(6'h10, r); chk("R8 ram kept after clear", r, 8'hEF);

        // R8: write to capture address has no effect
        wr(6'h10, 8'h55);
        rd(6'h10, r); chk("R8 capture write ignored", r, 8'hEF);

        // R6: disabled flash event ignored (flash enables off)
        wr(6'h00, 8'h22);
        pulse(4'b0011);
        rd(6'h01, r); chk("R6 status unchanged", r, 8'h00);
        rd(6'h20, r); chk("R6 flash capture unchanged", r, 8'h00);
        chk("R6 irq low", {7'b0, irq}, 8'h00);

        // R8: flash event updates only flash record
        wr(6'h00, 8'h33);
        ram_data = 32'h1111_1111;
        pulse(4'b0001);
        rd(6'h20, r); chk("R7 flash data lsb", r, 8'h0D);
        rd(6'h24, r); chk("R7 flash attr", r, 8'h3C);
        rd(6'h10, r); chk("R8 ram kept on flash event", r, 8'hEF);

        // R9: event in the same cycle as a clear wins
        @(negedge clk);
        reg_addr = 6'h01; reg_wdata = 8'hFF; reg_wr = 1'b1; fl_sbit = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; fl_sbit = 1'b0;
        rd(6'h01, r); chk("R9 event beats clear", r, 8'h10);

        // R3: with permission removed, clearing still works and setting does not
        soc_sbit_en = 1'b0;
        wr(6'h00, 8'h00);
        wr(6'h00, 8'h30);
        rd(6'h00, r); chk("R3 set blocked", r, 8'h00);

        // R1: reset again clears everything
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(6'h01, r); chk("R1 status after reset", r, 8'h00);
        rd(6'h14, r); chk("R1 ram attr after reset", r, 8'h00);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule